// File: doc/BRIEF.md
# Comparator Status and Interrupt Controller

This block is the digital wrapper around an analog comparator. The raw comparator output arrives asynchronously. A chain of flip-flops brings it into the clock domain, and the synchronized level can be read back. A mode field selects which transitions of that level count as events. An event sets a sticky interrupt flag. The flag drives an interrupt request when both the local enable and the global enable input are set.

The block also drives three controls toward the analog side and a timer. The first selects the comparator's positive input, either the internal fixed reference or the external pin. The second powers the comparator down. The third is a capture-trigger output that forwards the synchronized comparator level to a timer's input-capture logic when routing is enabled.

Software sees one 8-bit control/status register through a single-cycle write strobe and a combinational read. The flag clears in two ways: by writing a one to its bit, or by the interrupt controller's vector acknowledge.

Top module: `cmp_irq_ctrl`

## Requirements
- R1: The register bits are: [7] disable, [6] reference select, [5] synchronized comparator level, [4] interrupt flag, [3] interrupt enable, [2] capture enable, [1:0] event mode.
- R2: After reset every register bit reads 0. Bit 5 is read-only, and a write to it has no effect on the read value.
- R3: A change on the raw comparator input shows in bit 5 after exactly 2 clock edges.
- R4: Mode 00 sets the flag on either edge, 01 never sets it, 10 sets it on a falling edge and 11 on a rising edge. Edges are taken between consecutive synchronized samples. The flag rises one edge after bit 5 changes.
- R5: Writing 1 to bit 4 clears the flag. Writing 0 to bit 4 leaves it unchanged.
- R6: An acknowledge pulse on irq_ack_i clears the flag on the next edge.
- R7: irq_o is high exactly when the flag, the interrupt enable bit and gie_i are all 1.
- R8: ref_sel_o equals bit 6 (1 = internal reference, 0 = external pin).
- R9: cap_trig_o follows the synchronized comparator level while bit 2 is 1, and is 0 while bit 2 is 0.
- R10: pwr_down_o equals bit 7.
- R11: While bit 7 is 1, the synchronizer input is forced to 0 and no event sets the flag. A flag that is already set stays set until it is cleared.
- R12: When a hardware event and a clear (write-one or acknowledge) fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_raw_i | input | 1 | Raw asynchronous comparator output |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt vector acknowledge; clears the flag |
| irq_o | output | 1 | Interrupt request |
| ref_sel_o | output | 1 | Positive input select: 1 = internal reference, 0 = pin |
| pwr_down_o | output | 1 | Comparator power-down |
| cap_trig_o | output | 1 | Trigger toward the timer input-capture unit |

## Verification
A stale previous-sample register or a wrong mode decode shows at the ports as a flag bit that rises for the wrong edge direction. The error appears in bit 4 three edges after the raw input changes. A synchronizer of the wrong depth moves the rise of bit 5 by one edge, so the bench samples the cycles on both sides of it. A wrong set/clear priority shows in the read value of the flag one edge after the collision. A disable gate that leaks lets the falling level forced into the synchronizer set the flag about three edges after disable is written.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  localparam int REG_W       = 8;
  localparam int BIT_DIS     = 7;
  localparam int BIT_REF     = 6;
  localparam int BIT_OUT     = 5;
  localparam int BIT_FLAG    = 4;
  localparam int BIT_IEN     = 3;
  localparam int BIT_CAP     = 2;
  localparam int BIT_MODE_HI = 1;
  localparam int BIT_MODE_LO = 0;

  typedef enum logic [1:0] {
    MODE_ANY  = 2'b00,
    MODE_NONE = 2'b01,
    MODE_FALL = 2'b10,
    MODE_RISE = 2'b11
  } cmp_mode_e;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_edge.sv
module cmp_edge
  import cmp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      lvl_i,
  input  logic      dis_i,
  input  cmp_mode_e mode_i,
  output logic      evt_o
);
  logic prev_q;
  logic rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  always_comb begin
    unique case (mode_i)
      MODE_ANY:  hit = rise | fall;
      MODE_NONE: hit = 1'b0;
      MODE_FALL: hit = fall;
      MODE_RISE: hit = rise;
      default:   hit = 1'b0;
    endcase
  end

  // no events while powered down
  assign evt_o = hit & ~dis_i;

  AST_EVT_ON_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (lvl_i != $past(lvl_i))) else $error("event without level change"); // R4
endmodule

// File: rtl/cmp_irq_ctrl.sv
module cmp_irq_ctrl
  import cmp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_raw_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             gie_i,
  input  logic             irq_ack_i,
  output logic             irq_o,
  output logic             ref_sel_o,
  output logic             pwr_down_o,
  output logic             cap_trig_o
);
  logic      dis_q, ref_q, ien_q, cap_q, flag_q;
  cmp_mode_e mode_q;
  logic      sync_lvl, evt, flag_clr;
  logic      unused_wbit;

  assign unused_wbit = reg_wdata_i[BIT_OUT];

  cmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cmp_raw_i & ~dis_q),
    .q_o    (sync_lvl)
  );

  cmp_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (sync_lvl),
    .dis_i  (dis_q),
    .mode_i (mode_q),
    .evt_o  (evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dis_q  <= 1'b0;
      ref_q  <= 1'b0;
      ien_q  <= 1'b0;
      cap_q  <= 1'b0;
      mode_q <= MODE_ANY;
    end else if (reg_we_i) begin
      dis_q  <= reg_wdata_i[BIT_DIS];
      ref_q  <= reg_wdata_i[BIT_REF];
      ien_q  <= reg_wdata_i[BIT_IEN];
      cap_q  <= reg_wdata_i[BIT_CAP];
      mode_q <= cmp_mode_e'(reg_wdata_i[BIT_MODE_HI:BIT_MODE_LO]);
    end
  end

  assign flag_clr = (reg_we_i & reg_wdata_i[BIT_FLAG]) | irq_ack_i;

  // hardware set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (evt)      flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[BIT_DIS]                 = dis_q;
    reg_rdata_o[BIT_REF]                 = ref_q;
    reg_rdata_o[BIT_OUT]                 = sync_lvl;
    reg_rdata_o[BIT_FLAG]                = flag_q;
    reg_rdata_o[BIT_IEN]                 = ien_q;
    reg_rdata_o[BIT_CAP]                 = cap_q;
    reg_rdata_o[BIT_MODE_HI:BIT_MODE_LO] = mode_q;
  end

  assign irq_o      = flag_q & ien_q & gie_i;
  assign ref_sel_o  = ref_q;
  assign pwr_down_o = dis_q;
  assign cap_trig_o = cap_q & sync_lvl;

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !evt) |=> !flag_q) else $error("ack did not clear flag"); // R6
  AST_WZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !irq_ack_i && !(reg_we_i && reg_wdata_i[BIT_FLAG])) |=> flag_q)
    else $error("flag lost without clear"); // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag_q) else $error("event lost"); // R12
  AST_DIS_NO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dis_q && !flag_q) |=> !flag_q) else $error("flag set while disabled"); // R11
endmodule

// File: tb/tb_cmp_irq_ctrl.sv
module tb_cmp_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] F = 8'h10;
  // {mode[1:0], start level, end level, expected flag}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00_0_1_1, 5'b00_1_0_1, 5'b01_0_1_0, 5'b01_1_0_0,
    5'b10_0_1_0, 5'b10_1_0_1, 5'b11_0_1_1, 5'b11_1_0_0
  };

  logic clk = 1'b0, rst_ni = 1'b0, cmp_raw = 1'b0, we = 1'b0, gie = 1'b0, ack = 1'b0;
  logic [7:0] wd = '0, rd;
  logic irq, ref_sel, pwr_down, cap_trig;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_irq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cmp_raw_i(cmp_raw), .reg_we_i(we),
    .reg_wdata_i(wd), .reg_rdata_o(rd), .gie_i(gie), .irq_ack_i(ack),
    .irq_o(irq), .ref_sel_o(ref_sel), .pwr_down_o(pwr_down), .cap_trig_o(cap_trig)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    we = 1'b1; wd = d;
    @(negedge clk);
    we = 1'b0; wd = '0;
  endtask

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    step(2);
    rst_ni = 1'b1;
    step(1);
    chk("R2 reset value", rd, 8'h00);
    chk("R7 reset irq", {7'b0, irq}, 8'h00);
    wr(8'h20);
    chk("R2 read-only level bit", rd, 8'h00);
    wr(8'hCF);
    chk("R1 layout readback", rd, 8'hCF);
    chk("R8 ref select high", {7'b0, ref_sel}, 8'h01);
    chk("R10 power-down high", {7'b0, pwr_down}, 8'h01);
    wr(8'h00);
    chk("R8 ref select low", {7'b0, ref_sel}, 8'h00);
    chk("R10 power-down low", {7'b0, pwr_down}, 8'h00);

    // R4 mode table
    for (int i = 0; i < 8; i++) begin
      cmp_raw = VEC[i][2];
      step(4);
      wr(F | {6'b0, VEC[i][4:3]});
      cmp_raw = VEC[i][1];
      step(4);
      chk($sformatf("R4 vector %0d", i), {7'b0, rd[4]}, {7'b0, VEC[i][0]});
    end

    // R3 synchronizer lag, rising mode
    wr(F | 8'h03);
    cmp_raw = 1'b1;
    step(1);
    chk("R3 level after 1 edge", {7'b0, rd[5]}, 8'h00);
    step(1);
    chk("R3 level after 2 edges", {7'b0, rd[5]}, 8'h01);
    chk("R4 flag not yet set", {7'b0, rd[4]}, 8'h00);
    step(1);
    chk("R4 flag one edge later", {7'b0, rd[4]}, 8'h01);

    // R5 write-zero keeps, write-one clears
    wr(8'h03);
    chk("R5 write zero keeps flag", {7'b0, rd[4]}, 8'h01);
    wr(8'h13);
    chk("R5 write one clears flag", {7'b0, rd[4]}, 8'h00);

    // R7 request gating
    wr(F);
    cmp_raw = 1'b0;
    step(4);
    wr(8'h08);
    chk("R7 flag set ien set gie low", {7'b0, irq}, 8'h00);
    gie = 1'b1;
    #1;
    chk("R7 all enables", {7'b0, irq}, 8'h01);
    wr(8'h00);
    chk("R7 ien low", {7'b0, irq}, 8'h00);
    wr(8'h08);
    chk("R7 ien back high", {7'b0, irq}, 8'h01);

    // R6 acknowledge clears
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R6 ack clears flag", {7'b0, rd[4]}, 8'h00);
    chk("R6 irq drops", {7'b0, irq}, 8'h00);

    // R12 set beats write-one clear
    cmp_raw = 1'b1;
    step(2);
    we = 1'b1; wd = 8'h18;
    step(1);
    we = 1'b0; wd = '0;
    chk("R12 event beats write clear", {7'b0, rd[4]}, 8'h01);
    wr(8'h18);
    cmp_raw = 1'b0;
    step(2);
    ack = 1'b1;
    step(1);
    ack = 1'b0;
    chk("R12 event beats ack", {7'b0, rd[4]}, 8'h01);
    gie = 1'b0;

    // R9 capture routing
    wr(8'h10);
    cmp_raw = 1'b1;
    step(3);
    chk("R9 routing off", {7'b0, cap_trig}, 8'h00);
    wr(8'h04);
    chk("R9 routing on", {7'b0, cap_trig}, 8'h01);
    cmp_raw = 1'b0;
    step(2);
    chk("R9 follows level", {7'b0, cap_trig}, 8'h00);

    // R11 disable gating
    wr(F);
    cmp_raw = 1'b1;
    step(4);
    chk("R11 flag set before disable", {7'b0, rd[4]}, 8'h01);
    wr(8'h80);
    chk("R11 flag retained", {7'b0, rd[4]}, 8'h01);
    step(3);
    chk("R11 level forced low", {7'b0, rd[5]}, 8'h00);
    wr(8'h90);
    cmp_raw = 1'b0;
    step(3);
    cmp_raw = 1'b1;
    step(3);
    chk("R11 no events while disabled", rd, 8'h80);
    chk("R10 power-down while disabled", {7'b0, pwr_down}, 8'h01);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule